// File: doc/BRIEF.md
# Window Watchdog with Reset Sequencer

This block supervises a microcontroller. The controller proves it is alive by pulling an active-low trigger line low. The block answers with an active-low reset output. Time is measured in pulses of a tick enable that an external oscillator supplies. The minimum trigger width and the length of the reset pulse are counted in system clock cycles instead.

After power-up, and after every watchdog reset, the reset output is held low for a fixed number of clock cycles. Then a long lead window gives the controller time to deliver its first trigger. A valid trigger starts a closed window, in which any trigger counts as a fault and forces reset at once. The closed window is followed directly by an open window, in which a trigger is required. A trigger in the open window starts a fresh closed window, and silence until the open window ends causes a reset.

Triggers pass through a synchroniser and must stay low for a minimum number of cycles to count, so glitches are dropped. A low-power input switches the whole watchdog off. When that input is released, the lead window starts again.

Top module: `win_watchdog`

## Requirements
- R1: While `rst_n` is low at a clock edge, `wdg_rst_n` is 0 and `phase` reads 0 (reset phase).
- R2: Each reset pulse, whether after power-up or after a watchdog fault, keeps `wdg_rst_n` low for `RST_CYC` clock cycles. The block then enters the lead phase (`phase` = 1) with `wdg_rst_n` high.
- R3: If no valid trigger arrives within `LEAD_TICKS` tick pulses of the lead phase, the block enters the reset phase (`phase` = 0, `wdg_rst_n` low).
- R4: A valid trigger in the lead phase moves the block to the closed phase (`phase` = 2) at once.
- R5: The closed phase lasts `CLOSED_TICKS` tick pulses and is then followed directly by the open phase (`phase` = 3).
- R6: A valid trigger in the closed phase moves the block to the reset phase immediately.
- R7: A valid trigger in the open phase moves the block to a new closed phase.
- R8: If the open phase runs for `OPEN_TICKS` tick pulses without a valid trigger, the block enters the reset phase.
- R9: A trigger is valid only when its synchronised level has stayed low for `MINW_CYC` consecutive clock cycles after a high-to-low change. Shorter low pulses are ignored. A level held low counts as one trigger only.
- R10: A trigger that becomes valid during the reset phase is ignored. The following lead phase starts as normal and stays in lead.
- R11: While `lp_mode` is high, `phase` reads 4 (off), `wdg_rst_n` stays high and triggers have no effect. After `lp_mode` falls, the block enters the lead phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| tick | input | 1 | One-cycle enable from the watchdog oscillator |
| trig_n | input | 1 | Active-low trigger from the supervised controller (asynchronous) |
| lp_mode | input | 1 | High selects low-power mode and turns the watchdog off (asynchronous) |
| wdg_rst_n | output | 1 | Active-low reset to the supervised controller |
| phase | output | 3 | Current phase: 0 reset, 1 lead, 2 closed, 3 open, 4 off |

## Verification
The hardest situations to reach are a trigger inside the short closed window and a trigger that becomes valid while the reset pulse is still running. Both need stimulus placed in relation to a phase change. The bench waits on the `phase` output until the block reaches the target phase. It then issues a second full-width trigger right after a first one has opened the closed window. It also issues a trigger at the very start of a reset pulse, so that qualification finishes before the pulse ends. Glitch rejection and level-held triggers are covered by pulses just below the minimum width and by a low level held across a whole closed window.

// File: rtl/wdg_pkg.sv
// Package: shared phase encoding for the window watchdog.
// Assumes: the numeric values are visible on the top-level phase output.
package wdg_pkg;
    typedef enum logic [2:0] {
        PH_RESET  = 3'd0,
        PH_LEAD   = 3'd1,
        PH_CLOSED = 3'd2,
        PH_OPEN   = 3'd3,
        PH_OFF    = 3'd4
    } phase_t;
endpackage

// File: rtl/wdg_sync.sv
// Module: multi-stage synchroniser for a vector of asynchronous inputs.
// Assumes: every bit is an independent slow level; INIT gives the idle value
// loaded on reset so no false edge appears when reset is released.
module wdg_sync #(
    parameter int          W      = 2,
    parameter int          STAGES = 2,
    parameter logic [W-1:0] INIT  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // Capture the raw inputs into the first stage.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[0] <= INIT;
                else        stg[0] <= d;
            end
        end else begin : g_rest
            // Shift the value one stage further along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= INIT;
                else        stg[g] <= stg[g-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/wdg_trig_qual.sv
// Module: trigger qualifier. It arms on a high level, counts consecutive low
// cycles after a fall, and emits a one-cycle pulse when the low level has
// lasted MINW_CYC cycles. It then stays disarmed until the line returns high.
// Assumes: trig_s is already synchronised; MINW_CYC >= 1.
module wdg_trig_qual #(
    parameter int MINW_CYC = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_s,
    output logic trig_ok
);
    localparam int CW = $clog2(MINW_CYC + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(MINW_CYC - 1);

    logic          armed;
    logic [CW-1:0] low_cnt;

    // Track the low width and fire once per qualified falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed   <= 1'b1;
            low_cnt <= '0;
            trig_ok <= 1'b0;
        end else begin
            trig_ok <= 1'b0;
            if (trig_s) begin
                armed   <= 1'b1;
                low_cnt <= '0;
            end else if (armed) begin
                if (low_cnt == CNT_LAST) begin
                    trig_ok <= 1'b1;
                    armed   <= 1'b0;
                    low_cnt <= '0;
                end else begin
                    low_cnt <= low_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/wdg_seq.sv
// Module: phase sequencer. It walks the reset, lead, closed and open phases,
// counts window lengths in tick pulses and the reset pulse in clock cycles,
// and parks in the off phase while low power is requested.
// Assumes: trig_ok is a one-cycle pulse; tick is a one-cycle enable.
module wdg_seq
    import wdg_pkg::*;
#(
    parameter int LEAD_TICKS   = 7895,
    parameter int CLOSED_TICKS = 1053,
    parameter int OPEN_TICKS   = 1105,
    parameter int RST_CYC      = 400000
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   tick,
    input  logic   trig_ok,
    input  logic   lp_s,
    output phase_t phase_q
);
    localparam int TMAX = (LEAD_TICKS > CLOSED_TICKS)
                        ? ((LEAD_TICKS > OPEN_TICKS) ? LEAD_TICKS : OPEN_TICKS)
                        : ((CLOSED_TICKS > OPEN_TICKS) ? CLOSED_TICKS : OPEN_TICKS);
    localparam int TW = $clog2(TMAX + 1);
    localparam int RW = $clog2(RST_CYC + 1);
    localparam logic [TW-1:0] LEAD_LAST   = TW'(LEAD_TICKS - 1);
    localparam logic [TW-1:0] CLOSED_LAST = TW'(CLOSED_TICKS - 1);
    localparam logic [TW-1:0] OPEN_LAST   = TW'(OPEN_TICKS - 1);
    localparam logic [RW-1:0] RST_LAST    = RW'(RST_CYC - 1);

    phase_t        phase_d;
    logic [TW-1:0] tcnt_q, tcnt_d;
    logic [RW-1:0] rcnt_q, rcnt_d;
    logic [TW-1:0] win_last;
    logic          win_end;

    // Select the last tick index of the window currently running.
    always_comb begin
        case (phase_q)
            PH_LEAD:   win_last = LEAD_LAST;
            PH_CLOSED: win_last = CLOSED_LAST;
            PH_OPEN:   win_last = OPEN_LAST;
            default:   win_last = '0;
        endcase
    end

    assign win_end = tick && (tcnt_q == win_last);

    // Work out the next phase and counter values.
    always_comb begin
        phase_d = phase_q;
        tcnt_d  = tcnt_q;
        rcnt_d  = rcnt_q;
        if (lp_s) begin
            phase_d = PH_OFF;
            tcnt_d  = '0;
            rcnt_d  = '0;
        end else begin
            case (phase_q)
                PH_RESET: begin
                    if (rcnt_q == RST_LAST) begin
                        phase_d = PH_LEAD;
                        rcnt_d  = '0;
                        tcnt_d  = '0;
                    end else begin
                        rcnt_d = rcnt_q + 1'b1;
                    end
                end
                PH_LEAD, PH_OPEN: begin
                    if (trig_ok) begin
                        phase_d = PH_CLOSED;
                        tcnt_d  = '0;
                    end else if (win_end) begin
                        phase_d = PH_RESET;
                        rcnt_d  = '0;
                        tcnt_d  = '0;
                    end else if (tick) begin
                        tcnt_d = tcnt_q + 1'b1;
                    end
                end
                PH_CLOSED: begin
                    if (trig_ok) begin
                        phase_d = PH_RESET;
                        rcnt_d  = '0;
                        tcnt_d  = '0;
                    end else if (win_end) begin
                        phase_d = PH_OPEN;
                        tcnt_d  = '0;
                    end else if (tick) begin
                        tcnt_d = tcnt_q + 1'b1;
                    end
                end
                default: begin
                    phase_d = PH_LEAD;
                    tcnt_d  = '0;
                    rcnt_d  = '0;
                end
            endcase
        end
    end

    // Hold the phase and both counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_RESET;
            tcnt_q  <= '0;
            rcnt_q  <= '0;
        end else begin
            phase_q <= phase_d;
            tcnt_q  <= tcnt_d;
            rcnt_q  <= rcnt_d;
        end
    end
endmodule

// File: rtl/win_watchdog.sv
// Module: window watchdog top. It synchronises the trigger and low-power
// inputs, qualifies triggers by width and sequences the watchdog windows.
// Assumes: tick comes from the oscillator domain already aligned to clk.
module win_watchdog
    import wdg_pkg::*;
#(
    parameter int LEAD_TICKS   = 7895,
    parameter int CLOSED_TICKS = 1053,
    parameter int OPEN_TICKS   = 1105,
    parameter int MINW_CYC     = 20,
    parameter int RST_CYC      = 400000,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       trig_n,
    input  logic       lp_mode,
    output logic       wdg_rst_n,
    output logic [2:0] phase
);
    logic [1:0] sync_q;
    logic       trig_s;
    logic       lp_s;
    logic       trig_ok;
    phase_t     phase_q;

    wdg_sync #(.W(2), .STAGES(SYNC_STAGES), .INIT(2'b01)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({lp_mode, trig_n}),
        .q     (sync_q)
    );

    assign trig_s = sync_q[0];
    assign lp_s   = sync_q[1];

    wdg_trig_qual #(.MINW_CYC(MINW_CYC)) u_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig_s  (trig_s),
        .trig_ok (trig_ok)
    );

    wdg_seq #(
        .LEAD_TICKS   (LEAD_TICKS),
        .CLOSED_TICKS (CLOSED_TICKS),
        .OPEN_TICKS   (OPEN_TICKS),
        .RST_CYC      (RST_CYC)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .trig_ok (trig_ok),
        .lp_s    (lp_s),
        .phase_q (phase_q)
    );

    assign phase     = phase_q;
    assign wdg_rst_n = (phase_q != PH_RESET);
endmodule

// File: rtl/wdg_checker.sv
// Module: assertion checker bound into the window watchdog top.
// Assumes: phase uses the package encoding; trig_ok is the qualifier pulse.
module wdg_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] phase,
    input logic       wdg_rst_n,
    input logic       trig_ok,
    input logic       lp_s
);
    p_lead_trig_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd1 && trig_ok && !lp_s) |=> (phase == 3'd2));

    p_closed_trig_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd2 && trig_ok && !lp_s) |=> (phase == 3'd0 && !wdg_rst_n));

    p_open_trig_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd3 && trig_ok && !lp_s) |=> (phase == 3'd2));

    p_trig_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        trig_ok |=> !trig_ok);

    p_reset_ignores_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd0 && trig_ok && !lp_s) |=> (phase != 3'd2));

    p_off_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd4) |-> wdg_rst_n);

    p_lead_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && phase == 3'd1 && $past(phase) != 3'd1)
        |-> ($past(phase) == 3'd0 || $past(phase) == 3'd4));
endmodule

bind win_watchdog wdg_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase     (phase),
    .wdg_rst_n (wdg_rst_n),
    .trig_ok   (trig_ok),
    .lp_s      (lp_s)
);

// File: tb/tb_win_watchdog.sv
`timescale 1ns/1ps
module tb_win_watchdog;
    localparam int LEAD   = 20;
    localparam int CLOSED = 8;
    localparam int OPEN   = 10;
    localparam int MINW   = 5;
    localparam int RSTC   = 30;
    localparam int TDIV   = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       trig_n = 1'b1;
    logic       lp_mode = 1'b0;
    logic       wdg_rst_n;
    logic [2:0] phase;

    int total = 0;
    int bad = 0;
    int cyc_all = 0;

    win_watchdog #(
        .LEAD_TICKS(LEAD), .CLOSED_TICKS(CLOSED), .OPEN_TICKS(OPEN),
        .MINW_CYC(MINW), .RST_CYC(RSTC), .SYNC_STAGES(2)
    ) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .trig_n(trig_n),
        .lp_mode(lp_mode), .wdg_rst_n(wdg_rst_n), .phase(phase)
    );

    always #5 clk = ~clk;

    // Tick enable: one cycle in every TDIV, changed on falling edges.
    initial begin
        forever begin
            for (int i = 0; i < TDIV; i++) begin
                @(negedge clk);
                tick = (i == TDIV - 1);
            end
        end
    end

    // Watchdog for the bench itself.
    always @(posedge clk) begin
        cyc_all <= cyc_all + 1;
        if (cyc_all == 20000) begin
            $display("FAIL watchdog: run hung, got %0d cycles expected < 20000", cyc_all);
            bad = bad + 1;
            total = total + 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_rng(input string req, input int act, input int lo, input int hi);
        total++;
        if (act < lo || act > hi) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    // Count falling edges until phase reaches the target; -1 on timeout.
    task automatic wait_phase(input logic [2:0] tgt, input int maxc, output int n);
        n = 0;
        while (phase != tgt && n <= maxc) begin
            @(negedge clk);
            n++;
        end
        if (phase != tgt) n = -1;
    endtask

    task automatic pulse(input int w);
        @(negedge clk);
        trig_n = 1'b0;
        repeat (w) @(negedge clk);
        trig_n = 1'b1;
    endtask

    task automatic t_reset();
        int n;
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        chk(phase == 3'd0, "R1 phase in reset", phase, 0);
        chk(wdg_rst_n == 1'b0, "R1 reset output", wdg_rst_n, 0);
        rst_n = 1'b1;
        wait_phase(3'd1, 200, n);
        chk_rng("R2 power-up pulse length", n, RSTC - 1, RSTC + 1);
        chk(wdg_rst_n == 1'b1, "R2 released after pulse", wdg_rst_n, 1);
    endtask

    task automatic t_lead_timeout();
        int n;
        wait_phase(3'd0, 500, n);
        chk_rng("R3 lead timeout", n, (LEAD - 1) * TDIV, LEAD * TDIV + 2);
        wait_phase(3'd1, 200, n);
        chk_rng("R2 fault pulse length", n, RSTC - 1, RSTC + 1);
    endtask

    task automatic t_glitch();
        pulse(MINW - 3);
        repeat (20) @(negedge clk);
        chk(phase == 3'd1, "R9 glitch ignored", phase, 1);
    endtask

    task automatic t_lead_trig_and_closed();
        int n;
        pulse(MINW + 5);
        wait_phase(3'd2, 30, n);
        chk(n >= 0, "R4 lead trigger to closed", phase, 2);
        wait_phase(3'd3, 300, n);
        chk_rng("R5 closed length", n, (CLOSED - 1) * TDIV - 8, CLOSED * TDIV + 2);
    endtask

    task automatic t_open_trig();
        int n;
        pulse(MINW + 5);
        wait_phase(3'd2, 30, n);
        chk(n >= 0, "R7 open trigger restarts closed", phase, 2);
    endtask

    task automatic t_held_low();
        int n;
        wait_phase(3'd3, 300, n);
        @(negedge clk);
        trig_n = 1'b0;
        repeat (60) @(negedge clk);
        chk(phase == 3'd3, "R9 held low counts once", phase, 3);
        trig_n = 1'b1;
    endtask

    task automatic t_early();
        int n;
        pulse(MINW + 5);
        wait_phase(3'd2, 30, n);
        pulse(MINW + 5);
        wait_phase(3'd0, 30, n);
        chk(n >= 0, "R6 early trigger resets", phase, 0);
        chk(wdg_rst_n == 1'b0, "R6 reset output low", wdg_rst_n, 0);
    endtask

    task automatic t_reset_ignore();
        int n;
        pulse(MINW + 3);
        wait_phase(3'd1, 100, n);
        repeat (15) @(negedge clk);
        chk(phase == 3'd1, "R10 trigger during reset ignored", phase, 1);
    endtask

    task automatic t_miss_open();
        int n;
        pulse(MINW + 5);
        wait_phase(3'd3, 300, n);
        wait_phase(3'd0, 300, n);
        chk_rng("R8 open expiry", n, (OPEN - 1) * TDIV, OPEN * TDIV + 2);
    endtask

    task automatic t_sleep();
        int n;
        int viol = 0;
        wait_phase(3'd1, 200, n);
        lp_mode = 1'b1;
        repeat (5) @(negedge clk);
        chk(phase == 3'd4, "R11 off phase", phase, 4);
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (i == 50 || i == 150) trig_n = 1'b0;
            if (i == 60 || i == 160) trig_n = 1'b1;
            if (wdg_rst_n !== 1'b1 || phase != 3'd4) viol++;
        end
        chk(viol == 0, "R11 no reset while off", viol, 0);
        lp_mode = 1'b0;
        wait_phase(3'd1, 10, n);
        chk(n >= 0, "R11 wake enters lead", phase, 1);
    endtask

    initial begin
        t_reset();
        t_lead_timeout();
        t_glitch();
        t_lead_trig_and_closed();
        t_open_trig();
        t_held_low();
        t_early();
        t_reset_ignore();
        t_miss_open();
        t_sleep();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule